// File: doc/BRIEF.md
# Serial Register Access Master (24-bit, three-wire)

This block lets on-chip logic read and write the 16-bit registers of an external display bridge over a three-wire serial link. A client presents a register number, a read/write flag and 16 bits of write data for one cycle. The block turns that request into two serial frames of 24 bits each, every frame enclosed by its own chip-select window. It pulses `done` when the second frame ends, and on a read it returns 16 bits on `rdata`.

The first frame carries the register number. The second frame carries either the write data or a read marker, and the bridge answers a read on the serial input during that frame. The serial clock half-period and the chip-select guard time are parameters counted in system clocks. A parameter also says whether a serial input is wired at all. Without one, reads return zero.

Top module: `bridge_reg_master`

## Requirements
- R1: After reset and whenever no access is in progress, `spi_cs_n`, `spi_sck` and `spi_mosi` are all 1, and `busy` and `done` are 0.
- R2: Every frame is exactly 24 bits, sent most significant bit first. While chip select is low, `spi_mosi` changes only in the cycle in which `spi_sck` falls.
- R3: Each bit has `spi_sck` low for HALF_CLKS cycles, then high for HALF_CLKS cycles. `spi_miso` is sampled in the last cycle of the low half.
- R4: Chip select falls GUARD_CLKS cycles before the first `spi_sck` fall of a frame. It rises HALF_CLKS+GUARD_CLKS cycles after the last `spi_sck` rise of that frame.
- R5: Within one access, chip select stays high for exactly GUARD_CLKS+1 cycles between the two frames. A frame starts only when the serial engine is idle.
- R6: The first frame holds 0x70 in bits 23:16, zero in bits 15:8 and the register number in bits 7:0.
- R7: For a write (`req_write`=1), the second frame holds 0x72 in bits 23:16 and the write data in bits 15:0.
- R8: For a read (`req_write`=0), the second frame is 0x730000. `rdata` is the last 16 bits sampled during that frame, and the earliest of these 16 bits lands in bit 15.
- R9: `done` is high for one cycle, in the first cycle in which chip select is high after the second frame. `rdata` takes its new value in that same cycle.
- R10: A request is accepted when `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the guard after the second frame has passed. `req_valid` is ignored while `busy` is 1.
- R11: With MISO_PRESENT=0, every read returns `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | REG_W | Register number |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress; requests ignored |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Read result |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the bridge |
| spi_miso | input | 1 | Serial data from the bridge |

## Verification
The hardest case to reach from the ports is a request that arrives in the short window between the two frames of an access. In that window the serial engine is idle and chip select is high, but the access is not finished. The bench keeps `req_valid` high, with a different register and operation, for the whole busy period of some accesses. It then checks that exactly two frames appeared and that both carry the original request. A responder model in the bench drives `spi_miso` on each falling clock edge from a chosen reply word, so that every read result can be computed in the bench from that word.

// File: rtl/brm_pkg.sv
package brm_pkg;
    localparam int PFX_W = 8;
    localparam logic [PFX_W-1:0] PFX_ADDR = 8'h70;
    localparam logic [PFX_W-1:0] PFX_WR   = 8'h72;
    localparam logic [PFX_W-1:0] PFX_RD   = 8'h73;

    typedef enum logic [2:0] {
        PH_IDLE, PH_LEAD, PH_LOW, PH_HIGH, PH_TRAIL, PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_FINISH
    } seq_e;
endpackage

// File: rtl/brm_frame_engine.sv
module brm_frame_engine
    import brm_pkg::*;
#(
    parameter int HALF_CLKS    = 4,
    parameter int GUARD_CLKS   = 8,
    parameter int FRAME_W      = 24,
    parameter int RX_W         = 16,
    parameter int MISO_PRESENT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               miso_i,
    output logic               idle_o,
    output logic               release_o,
    output logic [RX_W-1:0]    rx_o,
    output logic               cs_n_o,
    output logic               sck_o,
    output logic               mosi_o
);
    localparam int MAXC = (HALF_CLKS > GUARD_CLKS) ? HALF_CLKS : GUARD_CLKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BW   = $clog2(FRAME_W);
    localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CLKS - 1);
    localparam logic [CW-1:0] GUARD_LD = CW'(GUARD_CLKS - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      bitn;
        logic [FRAME_W-1:0] tx;
        logic [RX_W-1:0]    rx;
    } eng_t;

    eng_t eng_q, eng_d;
    logic expired;
    logic miso_bit;

    generate
        if (MISO_PRESENT != 0) begin : g_miso
            assign miso_bit = miso_i;
        end else begin : g_nomiso
            assign miso_bit = 1'b0;
        end
    endgenerate

    always_comb begin
        eng_d   = eng_q;
        expired = (eng_q.cnt == '0);
        if (eng_q.ph != PH_IDLE && !expired) begin
            eng_d.cnt = eng_q.cnt - 1'b1;
        end
        case (eng_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    eng_d.ph   = PH_LEAD;
                    eng_d.cnt  = GUARD_LD;
                    eng_d.bitn = '0;
                    eng_d.tx   = word_i;
                end
            end
            PH_LEAD: begin
                if (expired) begin
                    eng_d.ph  = PH_LOW;
                    eng_d.cnt = HALF_LD;
                end
            end
            PH_LOW: begin
                if (expired) begin
                    eng_d.rx  = {eng_q.rx[RX_W-2:0], miso_bit};
                    eng_d.ph  = PH_HIGH;
                    eng_d.cnt = HALF_LD;
                end
            end
            PH_HIGH: begin
                if (expired) begin
                    if (eng_q.bitn == LAST_BIT) begin
                        eng_d.ph  = PH_TRAIL;
                        eng_d.cnt = GUARD_LD;
                    end else begin
                        eng_d.ph   = PH_LOW;
                        eng_d.cnt  = HALF_LD;
                        eng_d.bitn = eng_q.bitn + 1'b1;
                        eng_d.tx   = {eng_q.tx[FRAME_W-2:0], 1'b0};
                    end
                end
            end
            PH_TRAIL: begin
                if (expired) begin
                    eng_d.ph  = PH_GAP;
                    eng_d.cnt = GUARD_LD;
                end
            end
            PH_GAP: begin
                if (expired) eng_d.ph = PH_IDLE;
            end
            default: eng_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q.ph   <= PH_IDLE;
            eng_q.cnt  <= '0;
            eng_q.bitn <= '0;
            eng_q.tx   <= '0;
            eng_q.rx   <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign idle_o    = (eng_q.ph == PH_IDLE);
    assign release_o = (eng_q.ph == PH_TRAIL) && expired;
    assign rx_o      = eng_q.rx;
    assign cs_n_o    = (eng_q.ph == PH_IDLE) || (eng_q.ph == PH_GAP);
    assign sck_o     = (eng_q.ph != PH_LOW);
    assign mosi_o    = (eng_q.ph == PH_LOW || eng_q.ph == PH_HIGH || eng_q.ph == PH_TRAIL)
                       ? eng_q.tx[FRAME_W-1] : 1'b1;

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start_i |-> idle_o); // R5
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n_o && $past(!cs_n_o) && !$fell(sck_o)) |-> $stable(mosi_o)); // R2
endmodule

// File: rtl/brm_sequencer.sv
module brm_sequencer
    import brm_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [REG_W-1:0]   req_reg,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               eng_idle,
    input  logic               eng_release,
    input  logic [DATA_W-1:0]  eng_rx,
    output logic               start_o,
    output logic [FRAME_W-1:0] word_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int PAY_W = FRAME_W - PFX_W;

    typedef struct packed {
        seq_e              st;
        logic              wr;
        logic [REG_W-1:0]  rg;
        logic [DATA_W-1:0] wd;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        start_o    = 1'b0;
        word_o     = '0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    seq_d.wr = req_write;
                    seq_d.rg = req_reg;
                    seq_d.wd = req_wdata;
                    seq_d.st = SQ_ADDR;
                    start_o  = 1'b1;
                    word_o   = {PFX_ADDR, PAY_W'(req_reg)};
                end
            end
            SQ_ADDR: begin
                if (eng_idle) begin
                    start_o  = 1'b1;
                    word_o   = seq_q.wr ? {PFX_WR, PAY_W'(seq_q.wd)} : {PFX_RD, PAY_W'(0)};
                    seq_d.st = SQ_DATA;
                end
            end
            SQ_DATA: begin
                if (eng_release) begin
                    seq_d.done  = 1'b1;
                    seq_d.rdata = eng_rx;
                    seq_d.st    = SQ_FINISH;
                end
            end
            SQ_FINISH: begin
                if (eng_idle) seq_d.st = SQ_IDLE;
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= SQ_IDLE;
            seq_q.wr    <= 1'b0;
            seq_q.rg    <= '0;
            seq_q.wd    <= '0;
            seq_q.done  <= 1'b0;
            seq_q.rdata <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o  = (seq_q.st != SQ_IDLE);
    assign done_o  = seq_q.done;
    assign rdata_o = seq_q.rdata;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
endmodule

// File: rtl/bridge_reg_master.sv
module bridge_reg_master
    import brm_pkg::*;
#(
    parameter int HALF_CLKS    = 4,
    parameter int GUARD_CLKS   = 8,
    parameter int REG_W        = 8,
    parameter int DATA_W       = 16,
    parameter int MISO_PRESENT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int FRAME_W = PFX_W + DATA_W;

    logic               start;
    logic [FRAME_W-1:0] word;
    logic               eng_idle;
    logic               eng_release;
    logic [DATA_W-1:0]  eng_rx;

    brm_sequencer #(
        .REG_W   (REG_W),
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_reg     (req_reg),
        .req_wdata   (req_wdata),
        .eng_idle    (eng_idle),
        .eng_release (eng_release),
        .eng_rx      (eng_rx),
        .start_o     (start),
        .word_o      (word),
        .busy_o      (busy),
        .done_o      (done),
        .rdata_o     (rdata)
    );

    brm_frame_engine #(
        .HALF_CLKS    (HALF_CLKS),
        .GUARD_CLKS   (GUARD_CLKS),
        .FRAME_W      (FRAME_W),
        .RX_W         (DATA_W),
        .MISO_PRESENT (MISO_PRESENT)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .word_i    (word),
        .miso_i    (spi_miso),
        .idle_o    (eng_idle),
        .release_o (eng_release),
        .rx_o      (eng_rx),
        .cs_n_o    (spi_cs_n),
        .sck_o     (spi_sck),
        .mosi_o    (spi_mosi)
    );

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (spi_cs_n && spi_sck && spi_mosi)); // R1
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(spi_cs_n)); // R9
endmodule

// File: tb/bridge_reg_master_tb.sv
module bridge_reg_master_tb;
    localparam int HALF  = 4;
    localparam int GUARD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_reg   = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, cs_n, sck, mosi;
    logic [15:0] rdata;
    logic        miso = 1'b1;
    logic        busy2, done2, cs2, sck2, mosi2;
    logic [15:0] rdata2;

    bridge_reg_master #(.HALF_CLKS(HALF), .GUARD_CLKS(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso)
    );

    bridge_reg_master #(.HALF_CLKS(HALF), .GUARD_CLKS(GUARD), .MISO_PRESENT(0)) u_nomiso (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy2), .done(done2),
        .rdata(rdata2), .spi_cs_n(cs2), .spi_sck(sck2), .spi_mosi(mosi2), .spi_miso(miso)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit armed = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Bench-side bridge model and line monitor
    logic [23:0] reply_word = '0;
    logic [23:0] cap;
    int nbits, idx, t_csf, t_first_fall, t_fall, t_rise;
    bit first_seen;
    logic [23:0] frames [0:7];
    int fbits [0:7], leads [0:7], trails [0:7], csf_t [0:7], csr_t [0:7];
    int nframes = 0;
    int lo_min, lo_max, hi_min, hi_max;
    int done_cnt = 0, t_done = 0, dbl = 0;
    bit prev_done = 0;

    always @(negedge cs_n) if (armed) begin
        t_csf = cyc; first_seen = 0; idx = 0;
    end

    always @(negedge sck) if (armed && !cs_n) begin
        if (!first_seen) begin
            first_seen = 1; t_first_fall = cyc;
        end else begin
            if (cyc - t_rise < hi_min) hi_min = cyc - t_rise;
            if (cyc - t_rise > hi_max) hi_max = cyc - t_rise;
        end
        t_fall = cyc;
        if (idx < 24) miso = reply_word[23 - idx];
        idx = idx + 1;
    end

    always @(posedge sck) if (armed && !cs_n) begin
        cap = {cap[22:0], mosi};
        nbits = nbits + 1;
        if (cyc - t_fall < lo_min) lo_min = cyc - t_fall;
        if (cyc - t_fall > lo_max) lo_max = cyc - t_fall;
        t_rise = cyc;
    end

    always @(posedge cs_n) if (armed) begin
        if (nframes < 8) begin
            frames[nframes] = cap;
            fbits[nframes]  = nbits;
            leads[nframes]  = t_first_fall - t_csf;
            trails[nframes] = cyc - t_rise;
            csf_t[nframes]  = t_csf;
            csr_t[nframes]  = cyc;
        end
        nframes = nframes + 1;
        cap = '0; nbits = 0;
        miso = 1'b1;
    end

    always @(negedge clk) if (armed) begin
        if (done) begin
            done_cnt = done_cnt + 1; t_done = cyc;
        end
        if (done && prev_done) dbl = dbl + 1;
        prev_done = done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] rg, input logic [15:0] wd,
                          input logic [23:0] rep, input bit poke);
        int dc0;
        int to;
        logic [23:0] exp2;
        dc0 = done_cnt;
        nframes = 0; cap = '0; nbits = 0;
        lo_min = 1000; lo_max = 0; hi_min = 1000; hi_max = 0;
        reply_word = rep;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
        to = 0;
        while (busy && to < 3000) begin
            if (poke) begin
                req_valid = 1'b1; req_write = ~wr; req_reg = ~rg; req_wdata = ~wd;
            end
            @(negedge clk);
            to++;
        end
        req_valid = 1'b0;
        chk(to < 3000, "R10 busy released", to, 0);
        chk(nframes == 2, "R10 two frames per access", nframes, 2);
        chk(frames[0] == {8'h70, 8'h00, rg}, "R6 address frame", int'(frames[0]), int'({8'h70, 8'h00, rg}));
        exp2 = wr ? {8'h72, wd} : 24'h730000;
        chk(frames[1] == exp2, wr ? "R7 write frame" : "R8 read frame", int'(frames[1]), int'(exp2));
        chk(fbits[0] == 24 && fbits[1] == 24, "R2 bits per frame", fbits[0] * 100 + fbits[1], 2424);
        chk(lo_min == HALF && lo_max == HALF, "R3 sck low width", lo_min * 100 + lo_max, HALF * 101);
        chk(hi_min == HALF && hi_max == HALF, "R3 sck high width", hi_min * 100 + hi_max, HALF * 101);
        chk(leads[0] == GUARD && leads[1] == GUARD, "R4 lead guard", leads[0] * 100 + leads[1], GUARD * 101);
        chk(trails[0] == HALF + GUARD && trails[1] == HALF + GUARD, "R4 trail guard",
            trails[0] * 100 + trails[1], (HALF + GUARD) * 101);
        chk(csf_t[1] - csr_t[0] == GUARD + 1, "R5 inter-frame gap", csf_t[1] - csr_t[0], GUARD + 1);
        chk(done_cnt - dc0 == 1 && dbl == 0, "R9 single done pulse", done_cnt - dc0, 1);
        chk(t_done == csr_t[1], "R9 done at chip-select release", t_done, csr_t[1]);
        if (!wr) begin
            chk(rdata == rep[15:0], "R8 read data", int'(rdata), int'(rep[15:0]));
            chk(rdata2 == 16'h0, "R11 no serial input reads zero", int'(rdata2), 0);
        end
        chk(cs_n && sck && mosi && !busy && !done, "R1 idle lines after access",
            int'({cs_n, sck, mosi, busy, done}), 5'b11100);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        @(negedge clk);
        chk(cs_n && sck && mosi, "R1 reset lines high", int'({cs_n, sck, mosi}), 3'b111);
        chk(!busy && !done, "R1 reset busy/done low", int'({busy, done}), 0);
        access(1'b1, 8'h00, 16'h0000, 24'hFFFFFF, 1'b0);
        access(1'b1, 8'hFF, 16'hFFFF, 24'h000000, 1'b0);
        access(1'b0, 8'hB0, 16'h0000, 24'h002828, 1'b0);
        access(1'b0, 8'hFF, 16'h1234, 24'hFFFFFF, 1'b1);
        access(1'b0, 8'h01, 16'h0000, 24'hFF0000, 1'b0);
        for (int i = 0; i < 12; i++) begin
            access(i[0], 8'(i * 21 + 3), 16'(i * 4099) ^ 16'hA5C3,
                   24'(i * 32'h13579 + 32'h5A0F0F), (i % 3) == 2);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule